// File: doc/BRIEF.md
# Host Command Mailbox Register Bank

This block is the register side of a host-to-engine mailbox. A host processor reaches it over an AXI-Lite slave port. Through it the host hands simple read or write requests to a slow local command engine. Four 32-bit words make up the mailbox: a command/status word, a control word that carries the opcode and its operand, an outbound data word, and an inbound data word that only the engine fills. Executing the commands is not part of this block.

The engine watches a pair of registered request pulses. Each pulse comes with a snapshot of the decoded command fields. The engine answers through a parallel status port that can set completion and drive the busy and error flags, and through a data port that loads the inbound word. The status bits are shared between the two sides. Only the engine can raise completion, and only a host write can lower it. An error flag is visible only while completion is also visible. A transaction ends when the host writes zero to the command/status and control words, which re-arms the request detection.

Top module: `mbx_host_mailbox`

## Requirements
- R1: Word offsets are 0x0 command/status, 0x4 control, 0x8 outbound data and 0xC inbound data (the address bits below bit 2 are ignored). A read of any other offset returns zero with an OKAY (00) response.
- R2: A write is accepted in a cycle where both address and data are valid and no write response is pending. The write response (OKAY) stays valid until it is taken. A read response stays valid with stable data until it is taken.
- R3: The command/status word reads as bit0 read request, bit1 write request, bit2 done, bit3 busy, bit4 error and bits[6:5] byte offset, with bits[31:7] reading zero. The host writes it through byte lane 0.
- R4: Only the engine status port can set the done bit. A host write with bit2 at zero clears it, and a host write with bit2 at one leaves it unchanged.
- R5: When a host write to the command/status word and an engine status update land in the same cycle, the engine decides done (by OR with its set request), busy and error, and the host write decides the other bits.
- R6: The error bit reads as one only while the done bit is set.
- R7: The inbound data word changes only on an engine data load. A host write to offset 0xC has no effect.
- R8: Host writes to the control and outbound data words honour the byte strobes.
- R9: A one-cycle request pulse appears in the second cycle after the command/status word comes to hold read=1, write=0, done=0, busy=0 (read pulse) or read=0, write=1, done=0, busy=0 (write pulse). No pulse appears when both request bits are set.
- R10: With each pulse the engine outputs load the opcode (control bits[7:0]), port (bits[15:8]), word address (bits[25:2]), byte offset (status bits[6:5]) and outbound data. These outputs hold between pulses.
- R11: Once the host has written zero to the command/status word, a new request of the same kind produces a fresh pulse.
- R12: After reset all four words read zero, and no response or request pulse is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| eng_pend_rd | output | 1 | Read request pulse |
| eng_pend_wr | output | 1 | Write request pulse |
| eng_opcode | output | OPC_W | Captured opcode |
| eng_port | output | PORT_W | Captured port number |
| eng_addr | output | WADDR_W | Captured word address |
| eng_boff | output | 2 | Captured byte offset |
| eng_wdata | output | 32 | Captured outbound data |
| eng_sts_valid | input | 1 | Engine status update strobe |
| eng_set_ack | input | 1 | Engine sets done |
| eng_busy | input | 1 | Engine busy value |
| eng_err | input | 1 | Engine error value |
| eng_rdata_valid | input | 1 | Engine loads inbound data |
| eng_rdata | input | 32 | Inbound data value |

## Verification
Checker properties are evaluated on every cycle. They cover the ownership of the done bit (it rises only after an engine set and falls only after a host write to the status word), the mutual exclusion and single-cycle width of the request pulses, the hold of the captured fields between pulses, the immunity of the inbound word to anything but an engine load, and the hold of both bus responses under back-pressure. Other behaviours depend on values and order, and only the bench scenarios show them: the readback layout and error masking, same-cycle contention, byte strobes, unmapped offsets, the ignored host write to the inbound word, and re-arming after a cleared transaction.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned IDX_CS   = 0;
  localparam int unsigned IDX_CTRL = 1;
  localparam int unsigned IDX_WDAT = 2;
  localparam int unsigned IDX_RDAT = 3;

  // command/status word, MSB first: boff[6:5], err, busy, ack, wr, rd
  typedef struct packed {
    logic [1:0] boff;
    logic       err;
    logic       busy;
    logic       ack;
    logic       wr;
    logic       rd;
  } cs_t;

  localparam int unsigned CS_W      = $bits(cs_t);
  localparam int unsigned OPC_LSB   = 0;
  localparam int unsigned PORT_LSB  = 8;
  localparam int unsigned WADDR_LSB = 2;
endpackage

// File: rtl/mbx_axil_port.sv
module mbx_axil_port #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W  = ADDR_W - 2,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_value
);
  logic              bvalid_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              wr_fire;
  logic              rd_fire;
  logic              unused_lsb;

  assign wr_fire    = s_awvalid && s_wvalid && !bvalid_q;
  assign rd_fire    = s_arvalid && !rvalid_q;
  assign s_awready  = wr_fire;
  assign s_wready   = wr_fire;
  assign s_arready  = rd_fire;
  assign wr_en      = wr_fire;
  assign wr_idx     = s_awaddr[ADDR_W-1:2];
  assign rd_idx     = s_araddr[ADDR_W-1:2];
  assign wr_data    = s_wdata;
  assign wr_strb    = s_wstrb;
  assign unused_lsb = ^{s_awaddr[1:0], s_araddr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_fire)       bvalid_q <= 1'b1;
      else if (s_bready) bvalid_q <= 1'b0;
      if (rd_fire) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_value;
      end else if (s_rready) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign s_bvalid = bvalid_q;
  assign s_rvalid = rvalid_q;
  assign s_rdata  = rdata_q;
  assign s_bresp  = 2'b00;
  assign s_rresp  = 2'b00;
endmodule

// File: rtl/mbx_word_reg.sv
module mbx_word_reg #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [STRB_W-1:0] strb,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                q[8*b +: 8] <= '0;
      else if (we && strb[b]) q[8*b +: 8] <= d[8*b +: 8];
    end
  end
endmodule

// File: rtl/mbx_status_reg.sv
module mbx_status_reg
  import mbx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic host_we,
  input  cs_t  host_val,
  input  logic eng_valid,
  input  logic eng_set_ack,
  input  logic eng_busy,
  input  logic eng_err,
  output cs_t  cs_q
);
  cs_t nxt;

  always_comb begin
    nxt = cs_q;
    if (host_we) begin
      nxt.rd   = host_val.rd;
      nxt.wr   = host_val.wr;
      nxt.busy = host_val.busy;
      nxt.err  = host_val.err;
      nxt.boff = host_val.boff;
      nxt.ack  = cs_q.ack & host_val.ack;   // host may only clear
    end
    if (eng_valid) begin                    // engine wins its bits
      nxt.ack  = nxt.ack | eng_set_ack;
      nxt.busy = eng_busy;
      nxt.err  = eng_err;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cs_q <= '0;
    else     cs_q <= nxt;
  end
endmodule

// File: rtl/mbx_cmd_dispatch.sv
module mbx_cmd_dispatch
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned OPC_W   = 8,
  parameter int unsigned PORT_W  = 8,
  parameter int unsigned WADDR_W = 24,
  localparam int unsigned TOP_USED = WADDR_LSB + WADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  cs_t                cs,
  input  logic [DATA_W-1:0]  ctrl,
  input  logic [DATA_W-1:0]  wdat,
  output logic               pend_rd,
  output logic               pend_wr,
  output logic [OPC_W-1:0]   opcode,
  output logic [PORT_W-1:0]  port,
  output logic [WADDR_W-1:0] addr,
  output logic [1:0]         boff,
  output logic [DATA_W-1:0]  wdata
);
  localparam int unsigned NKIND = 2;  // 0: read request, 1: write request

  logic [NKIND-1:0] cond;
  logic [NKIND-1:0] prev_q;
  logic [NKIND-1:0] pulse_q;
  logic [NKIND-1:0] rise;
  logic             unused_hi;

  assign cond[0] =  cs.rd && !cs.wr && !cs.ack && !cs.busy;
  assign cond[1] = !cs.rd &&  cs.wr && !cs.ack && !cs.busy;

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    assign rise[k] = cond[k] && !prev_q[k];
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[k]  <= 1'b0;
        pulse_q[k] <= 1'b0;
      end else begin
        prev_q[k]  <= cond[k];
        pulse_q[k] <= rise[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode <= '0;
      port   <= '0;
      addr   <= '0;
      boff   <= '0;
      wdata  <= '0;
    end else if (|rise) begin
      opcode <= ctrl[OPC_LSB +: OPC_W];
      port   <= ctrl[PORT_LSB +: PORT_W];
      addr   <= ctrl[WADDR_LSB +: WADDR_W];
      boff   <= cs.boff;
      wdata  <= wdat;
    end
  end

  assign pend_rd   = pulse_q[0];
  assign pend_wr   = pulse_q[1];
  assign unused_hi = ^ctrl[DATA_W-1:TOP_USED];
endmodule

// File: rtl/mbx_host_mailbox.sv
module mbx_host_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned OPC_W   = 8,
  parameter int unsigned PORT_W  = 8,
  parameter int unsigned WADDR_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s_awvalid,
  output logic               s_awready,
  input  logic [ADDR_W-1:0]  s_awaddr,
  input  logic               s_wvalid,
  output logic               s_wready,
  input  logic [31:0]        s_wdata,
  input  logic [3:0]         s_wstrb,
  output logic               s_bvalid,
  input  logic               s_bready,
  output logic [1:0]         s_bresp,
  input  logic               s_arvalid,
  output logic               s_arready,
  input  logic [ADDR_W-1:0]  s_araddr,
  output logic               s_rvalid,
  input  logic               s_rready,
  output logic [31:0]        s_rdata,
  output logic [1:0]         s_rresp,
  output logic               eng_pend_rd,
  output logic               eng_pend_wr,
  output logic [OPC_W-1:0]   eng_opcode,
  output logic [PORT_W-1:0]  eng_port,
  output logic [WADDR_W-1:0] eng_addr,
  output logic [1:0]         eng_boff,
  output logic [31:0]        eng_wdata,
  input  logic               eng_sts_valid,
  input  logic               eng_set_ack,
  input  logic               eng_busy,
  input  logic               eng_err,
  input  logic               eng_rdata_valid,
  input  logic [31:0]        eng_rdata
);
  localparam int unsigned DATA_W = 32;
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned IDX_W  = ADDR_W - 2;

  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic [STRB_W-1:0] wr_strb;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_value;
  logic              host_cs_we;
  logic              ctrl_we;
  logic              wdat_we;
  cs_t               cs_q;
  cs_t               cs_view;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0] rdat_q;

  mbx_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_idx(rd_idx), .rd_value(rd_value)
  );

  assign host_cs_we = wr_en && (wr_idx == IDX_W'(IDX_CS)) && wr_strb[0];
  assign ctrl_we    = wr_en && (wr_idx == IDX_W'(IDX_CTRL));
  assign wdat_we    = wr_en && (wr_idx == IDX_W'(IDX_WDAT));

  mbx_status_reg u_status (
    .clk(clk), .rst(rst),
    .host_we(host_cs_we), .host_val(cs_t'(wr_data[CS_W-1:0])),
    .eng_valid(eng_sts_valid), .eng_set_ack(eng_set_ack),
    .eng_busy(eng_busy), .eng_err(eng_err),
    .cs_q(cs_q)
  );

  mbx_word_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .we(ctrl_we), .strb(wr_strb), .d(wr_data), .q(ctrl_q)
  );

  mbx_word_reg #(.DATA_W(DATA_W)) u_wdat (
    .clk(clk), .rst(rst), .we(wdat_we), .strb(wr_strb), .d(wr_data), .q(wdat_q)
  );

  mbx_word_reg #(.DATA_W(DATA_W)) u_rdat (
    .clk(clk), .rst(rst), .we(eng_rdata_valid), .strb({STRB_W{1'b1}}),
    .d(eng_rdata), .q(rdat_q)
  );

  always_comb begin
    cs_view     = cs_q;
    cs_view.err = cs_q.err & cs_q.ack;   // error qualified by done
  end

  always_comb begin
    case (rd_idx)
      IDX_W'(IDX_CS):   rd_value = {{(DATA_W-CS_W){1'b0}}, cs_view};
      IDX_W'(IDX_CTRL): rd_value = ctrl_q;
      IDX_W'(IDX_WDAT): rd_value = wdat_q;
      IDX_W'(IDX_RDAT): rd_value = rdat_q;
      default:          rd_value = '0;
    endcase
  end

  mbx_cmd_dispatch #(
    .DATA_W(DATA_W), .OPC_W(OPC_W), .PORT_W(PORT_W), .WADDR_W(WADDR_W)
  ) u_dispatch (
    .clk(clk), .rst(rst),
    .cs(cs_q), .ctrl(ctrl_q), .wdat(wdat_q),
    .pend_rd(eng_pend_rd), .pend_wr(eng_pend_wr),
    .opcode(eng_opcode), .port(eng_port), .addr(eng_addr),
    .boff(eng_boff), .wdata(eng_wdata)
  );
endmodule

// File: rtl/mbx_host_mailbox_chk.sv
module mbx_host_mailbox_chk #(
  parameter int unsigned OPC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ack,
  input logic             host_cs_we,
  input logic             eng_sts_valid,
  input logic             eng_set_ack,
  input logic             eng_pend_rd,
  input logic             eng_pend_wr,
  input logic [OPC_W-1:0] eng_opcode,
  input logic [31:0]      eng_wdata,
  input logic             eng_rdata_valid,
  input logic [31:0]      rdat_q,
  input logic             s_bvalid,
  input logic             s_bready,
  input logic             s_rvalid,
  input logic             s_rready,
  input logic [31:0]      s_rdata
);
  assert_ack_set_by_engine_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(eng_sts_valid && eng_set_ack));

  assert_ack_cleared_by_host_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ack) |-> $past(host_cs_we));

  assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(eng_pend_rd && eng_pend_wr));

  assert_rd_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    eng_pend_rd |=> !eng_pend_rd);

  assert_wr_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    eng_pend_wr |=> !eng_pend_wr);

  assert_fields_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!eng_pend_rd && !eng_pend_wr) |-> ($stable(eng_opcode) && $stable(eng_wdata)));

  assert_inbound_owned_R7: assert property (@(posedge clk) disable iff (rst)
    !eng_rdata_valid |=> $stable(rdat_q));

  assert_bresp_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> s_bvalid);

  assert_rresp_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));
endmodule

bind mbx_host_mailbox mbx_host_mailbox_chk #(.OPC_W(OPC_W)) u_chk (
  .clk(clk), .rst(rst), .ack(cs_q.ack), .host_cs_we(host_cs_we),
  .eng_sts_valid(eng_sts_valid), .eng_set_ack(eng_set_ack),
  .eng_pend_rd(eng_pend_rd), .eng_pend_wr(eng_pend_wr),
  .eng_opcode(eng_opcode), .eng_wdata(eng_wdata),
  .eng_rdata_valid(eng_rdata_valid), .rdat_q(rdat_q),
  .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata)
);

// File: tb/mbx_host_mailbox_tb.sv
`timescale 1ns/1ps
module mbx_host_mailbox_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  logic        s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
  logic [5:0]  s_awaddr = 0, s_araddr = 0;
  logic [31:0] s_wdata = 0;
  logic [3:0]  s_wstrb = 0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp, eng_boff;
  logic [31:0] s_rdata, eng_wdata;
  logic        eng_pend_rd, eng_pend_wr;
  logic [7:0]  eng_opcode, eng_port;
  logic [23:0] eng_addr;
  logic        eng_sts_valid = 0, eng_set_ack = 0, eng_busy = 0, eng_err = 0;
  logic        eng_rdata_valid = 0;
  logic [31:0] eng_rdata = 0;

  mbx_host_mailbox u_dut (
    .clk(clk), .rst(rst),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .eng_pend_rd(eng_pend_rd), .eng_pend_wr(eng_pend_wr),
    .eng_opcode(eng_opcode), .eng_port(eng_port), .eng_addr(eng_addr),
    .eng_boff(eng_boff), .eng_wdata(eng_wdata),
    .eng_sts_valid(eng_sts_valid), .eng_set_ack(eng_set_ack),
    .eng_busy(eng_busy), .eng_err(eng_err),
    .eng_rdata_valid(eng_rdata_valid), .eng_rdata(eng_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit        m_rd, m_wr, m_ack, m_busy, m_err;
  bit [1:0]  m_boff;
  bit [31:0] m_ctrl, m_wdat, m_rdat;
  bit        m_bvalid, m_rvalid;
  bit [31:0] m_rdata;
  bit        m_prev_rd, m_prev_wr, m_pend_rd, m_pend_wr;
  bit [7:0]  m_opc, m_port;
  bit [23:0] m_addr;
  bit [1:0]  m_oboff;
  bit [31:0] m_owd;

  function automatic bit [31:0] model_read(input bit [5:0] a);
    case (a[5:2])
      4'd0: return {25'd0, m_boff, m_err & m_ack, m_busy, m_ack, m_wr, m_rd};
      4'd1: return m_ctrl;
      4'd2: return m_wdat;
      4'd3: return m_rdat;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit wf, rf, crd, cwr;
    bit [31:0] rv;
    if (rst) begin
      {m_rd, m_wr, m_ack, m_busy, m_err} = '0;
      m_boff = 0; m_ctrl = 0; m_wdat = 0; m_rdat = 0;
      m_bvalid = 0; m_rvalid = 0; m_rdata = 0;
      m_prev_rd = 0; m_prev_wr = 0; m_pend_rd = 0; m_pend_wr = 0;
      m_opc = 0; m_port = 0; m_addr = 0; m_oboff = 0; m_owd = 0;
    end else begin
      wf  = s_awvalid && s_wvalid && !m_bvalid;
      rf  = s_arvalid && !m_rvalid;
      rv  = model_read(s_araddr);
      crd = m_rd && !m_wr && !m_ack && !m_busy;
      cwr = !m_rd && m_wr && !m_ack && !m_busy;
      m_pend_rd = crd && !m_prev_rd;
      m_pend_wr = cwr && !m_prev_wr;
      m_prev_rd = crd;
      m_prev_wr = cwr;
      if (m_pend_rd || m_pend_wr) begin
        m_opc = m_ctrl[7:0]; m_port = m_ctrl[15:8]; m_addr = m_ctrl[25:2];
        m_oboff = m_boff; m_owd = m_wdat;
      end
      if (wf) m_bvalid = 1; else if (s_bready) m_bvalid = 0;
      if (rf) begin m_rvalid = 1; m_rdata = rv; end else if (s_rready) m_rvalid = 0;
      if (wf && s_awaddr[5:2] == 0 && s_wstrb[0]) begin
        m_rd = s_wdata[0]; m_wr = s_wdata[1]; m_ack = m_ack & s_wdata[2];
        m_busy = s_wdata[3]; m_err = s_wdata[4]; m_boff = s_wdata[6:5];
      end
      if (eng_sts_valid) begin
        m_ack = m_ack | eng_set_ack; m_busy = eng_busy; m_err = eng_err;
      end
      for (int b = 0; b < 4; b++) begin
        if (wf && s_wstrb[b] && s_awaddr[5:2] == 1) m_ctrl[8*b +: 8] = s_wdata[8*b +: 8];
        if (wf && s_wstrb[b] && s_awaddr[5:2] == 2) m_wdat[8*b +: 8] = s_wdata[8*b +: 8];
      end
      if (eng_rdata_valid) m_rdat = eng_rdata;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 bvalid", {31'd0, s_bvalid}, {31'd0, m_bvalid});
      chk("R2 rvalid", {31'd0, s_rvalid}, {31'd0, m_rvalid});
      if (m_rvalid) chk("R1/R3 rdata", s_rdata, m_rdata);
      chk("R9 pend_rd", {31'd0, eng_pend_rd}, {31'd0, m_pend_rd});
      chk("R9 pend_wr", {31'd0, eng_pend_wr}, {31'd0, m_pend_wr});
      chk("R10 opcode", {24'd0, eng_opcode}, {24'd0, m_opc});
      chk("R10 port", {24'd0, eng_port}, {24'd0, m_port});
      chk("R10 addr", {8'd0, eng_addr}, {8'd0, m_addr});
      chk("R10 boff", {30'd0, eng_boff}, {30'd0, m_oboff});
      chk("R10 wdata", eng_wdata, m_owd);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic hwr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = s; s_awvalid = 1; s_wvalid = 1;
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
  endtask

  task automatic hrd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    @(negedge clk);
    s_arvalid = 0;
    d = s_rdata;
  endtask

  task automatic expect_rd(input string tag, input logic [5:0] a, input logic [31:0] e);
    logic [31:0] v;
    hrd(a, v);
    chk(tag, v, e);
  endtask

  task automatic ests(input logic a, input logic b, input logic e);
    @(negedge clk);
    eng_sts_valid = 1; eng_set_ack = a; eng_busy = b; eng_err = e;
    @(negedge clk);
    eng_sts_valid = 0; eng_set_ack = 0; eng_busy = 0; eng_err = 0;
  endtask

  task automatic eload(input logic [31:0] d);
    @(negedge clk);
    eng_rdata_valid = 1; eng_rdata = d;
    @(negedge clk);
    eng_rdata_valid = 0;
  endtask

  // host status write and engine update in the same cycle
  task automatic both(input logic [31:0] d, input logic a, input logic b, input logic e);
    @(negedge clk);
    s_awaddr = 6'h00; s_wdata = d; s_wstrb = 4'hF; s_awvalid = 1; s_wvalid = 1;
    eng_sts_valid = 1; eng_set_ack = a; eng_busy = b; eng_err = e;
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    eng_sts_valid = 0; eng_set_ack = 0; eng_busy = 0; eng_err = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R12 reset state
    @(negedge clk);
    chk("R12 bvalid", {31'd0, s_bvalid}, 0);
    chk("R12 pend", {30'd0, eng_pend_rd, eng_pend_wr}, 0);
    expect_rd("R12 cs", 6'h00, 0);
    expect_rd("R12 ctrl", 6'h04, 0);
    expect_rd("R12 rdat", 6'h0C, 0);

    // read request flow: opcode 4, port 3
    hwr(6'h04, 32'h0000_0304, 4'hF);
    hwr(6'h00, 32'h1, 4'hF);
    @(negedge clk);
    chk("R9 read pulse", {31'd0, eng_pend_rd}, 1);
    chk("R10 opcode", {24'd0, eng_opcode}, 32'h4);
    chk("R10 port", {24'd0, eng_port}, 32'h3);
    @(negedge clk);
    chk("R9 pulse width", {31'd0, eng_pend_rd}, 0);
    ests(0, 1, 0);
    expect_rd("R3 busy readback", 6'h00, 32'h9);
    eload(32'hCAFE_0001);
    ests(1, 0, 0);
    expect_rd("R3 done readback", 6'h00, 32'h5);
    expect_rd("R7 inbound", 6'h0C, 32'hCAFE_0001);
    hwr(6'h00, 0, 4'hF);
    hwr(6'h04, 0, 4'hF);
    expect_rd("R11 cleared cs", 6'h00, 0);

    // write request, raw address, byte offset 3
    hwr(6'h04, 32'h0123_4505, 4'hF);
    hwr(6'h08, 32'hDEAD_BEEF, 4'hF);
    hwr(6'h00, 32'h62, 4'hF);
    @(negedge clk);
    chk("R9 write pulse", {31'd0, eng_pend_wr}, 1);
    chk("R10 addr", {8'd0, eng_addr}, 32'h0048_D141);
    chk("R10 boff", {30'd0, eng_boff}, 3);
    chk("R10 wdata", eng_wdata, 32'hDEAD_BEEF);
    hwr(6'h0C, 32'h1111_1111, 4'hF);
    expect_rd("R7 host write ignored", 6'h0C, 32'hCAFE_0001);
    ests(1, 0, 1);
    expect_rd("R6 error with done", 6'h00, 32'h76);
    hwr(6'h00, 32'h66, 4'hF);
    expect_rd("R4 host bit2=1 keeps done", 6'h00, 32'h66);
    hwr(6'h00, 0, 4'hF);
    expect_rd("R4 host clears done", 6'h00, 0);

    // host cannot set done, error masked, both request bits -> no pulse
    hwr(6'h00, 32'h7F, 4'hF);
    @(negedge clk);
    chk("R9 no pulse both set", {30'd0, eng_pend_rd, eng_pend_wr}, 0);
    expect_rd("R4/R6 host set attempt", 6'h00, 32'h6B);
    hwr(6'h00, 0, 4'hF);

    // same-cycle contention
    both(32'h1, 1, 0, 0);
    expect_rd("R5 engine sets done, host sets read", 6'h00, 32'h5);
    both(32'h0, 0, 1, 0);
    expect_rd("R5 engine busy wins", 6'h00, 32'h8);
    ests(0, 0, 0);
    expect_rd("R5 idle", 6'h00, 0);

    // byte strobes
    hwr(6'h04, 32'hFFFF_FFFF, 4'hF);
    hwr(6'h04, 32'h0000_0000, 4'h5);
    expect_rd("R8 ctrl strobes", 6'h04, 32'hFF00_FF00);
    hwr(6'h08, 32'h0000_AB00, 4'h2);
    expect_rd("R8 wdat strobes", 6'h08, 32'hDEAD_ABEF);

    // unmapped offsets and low address bits
    expect_rd("R1 unmapped 0x10", 6'h10, 0);
    chk("R1 rresp", {30'd0, s_rresp}, 0);
    expect_rd("R1 unmapped 0x3C", 6'h3C, 0);
    expect_rd("R1 low bits ignored", 6'h06, 32'hFF00_FF00);

    // back-pressure
    s_bready = 0;
    hwr(6'h08, 32'h1234_5678, 4'hF);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 bvalid held", {31'd0, s_bvalid}, 1);
    end
    chk("R2 bresp", {30'd0, s_bresp}, 0);
    s_bready = 1;
    @(negedge clk);
    chk("R2 bvalid released", {31'd0, s_bvalid}, 0);
    s_rready = 0;
    hrd(6'h08, v);
    chk("R2 read data", v, 32'h1234_5678);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 rvalid held", {31'd0, s_rvalid}, 1);
      chk("R2 rdata stable", s_rdata, 32'h1234_5678);
    end
    s_rready = 1;
    @(negedge clk);
    chk("R2 rvalid released", {31'd0, s_rvalid}, 0);

    // re-arm: new read request after clear
    hwr(6'h04, 32'h0000_00FF, 4'hF);
    hwr(6'h00, 32'h1, 4'hF);
    @(negedge clk);
    chk("R11 fresh pulse", {31'd0, eng_pend_rd}, 1);
    chk("R11 fresh opcode", {24'd0, eng_opcode}, 32'hFF);
    hwr(6'h00, 0, 4'hF);
    hwr(6'h00, 32'h1, 4'hF);
    @(negedge clk);
    chk("R11 second pulse", {31'd0, eng_pend_rd}, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule